// File: doc/BRIEF.md
# Vertical Blanking Line Gate

This block decides, line by line, whether the video output of an encoder must be forced to blanking level. It keeps its own scan-line counter. The counter is restarted by a frame marker and advanced by a line-start pulse. The block looks up the current line in the blanking ranges that belong to the selected video standard and scan mode. It combines the result with an active-low external blank pin and drives one composite blank signal that the video datapath obeys.

Software can open part of the vertical interval for displayed data by setting a VBI-video enable. Lines that carry closed captions, when their caption-field enable is set, are left to the caption logic: they are passed through whatever the VBI-video enable says. The external pin can blank any line at any time, including lines that the VBI-video enable has opened.

The line decision is registered once per line, at the clock edge where `line_start` is high. The external pin acts on the output in the same cycle. An elaboration parameter can instead register the pin, which costs one cycle of latency.

Top module: `vbi_line_gate`

## Requirements
- R1: While reset is held, and after reset until the first `line_start`, `blank_o` is 1.
- R2: A `line_start` together with `frame_start` makes the current line 1. A `line_start` alone adds one to the line number. The line after the last line of the frame is line 1. The last line is 525 for interlaced NTSC/PAL-M, 625 for interlaced PAL, 262 for non-interlaced NTSC/PAL-M and 312 for non-interlaced PAL.
- R3: With `pal_std`=0 (NTSC/PAL-M), `interlace`=1 and `vbi_en`=0, lines 1–21 and 263–284 are blanked and every other line is not blanked (with `blank_n`=1).
- R4: With `pal_std`=1 (B/D/G/H/I/N/Nc), `interlace`=1 and `vbi_en`=0, lines 1–23, 311–335 and 624–625 are blanked and all others are not.
- R5: With `interlace`=0 and `vbi_en`=0, NTSC/PAL-M blanks lines 1–17 and 261–262, and PAL blanks lines 1–22 and 311–312. All other lines are not blanked.
- R6: With `vbi_en`=1, the following lines are no longer blanked:
  - interlaced NTSC/PAL-M: lines 10–21 and 273–284;
  - interlaced PAL: lines 6–23 and 320–335;
  - non-interlaced NTSC/PAL-M: lines 10–21;
  - non-interlaced PAL: lines 7–23.

  Every other line keeps its R3–R5 result.
- R7: A caption line whose enable is set is not blanked, whatever `vbi_en` is. `cap1_en` selects line 21 for NTSC/PAL-M and line 22 for PAL. In interlaced mode, `cap2_en` selects line 284 for NTSC/PAL-M and line 335 for PAL. A caption line whose enable is clear follows R3–R6.
- R8: With the default `PIN_REG`=0, `blank_n`=0 forces `blank_o` to 1 in the same cycle on any line. When `blank_n` returns to 1, the line decision reappears.
- R9: The line decision changes only at a clock edge where `line_start` is 1. It shows on `blank_o` from that edge onward. Changes of the mode and enable inputs between line starts have no effect on `blank_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | One-cycle pulse at the start of each scan line |
| frame_start | input | 1 | Qualifies `line_start`: the new line is line 1 |
| pal_std | input | 1 | 0 = NTSC/PAL-M, 1 = PAL B/D/G/H/I/N/Nc |
| interlace | input | 1 | 1 = interlaced, 0 = non-interlaced |
| vbi_en | input | 1 | Opens the displayable lines of the vertical interval |
| cap1_en | input | 1 | Caption enable for the first-field caption line |
| cap2_en | input | 1 | Caption enable for the second-field caption line |
| blank_n | input | 1 | Active-low external blank |
| blank_o | output | 1 | Composite blank, 1 = blank the video |

## Verification
The line decision is due at the first falling clock edge after the rising edge that sampled `line_start`, so the bench samples `blank_o` there, half a cycle after the register has moved. The pin override has no register on its path in the default build. The bench drops `blank_n` between line starts, samples one nanosecond later, and checks again after releasing it. To show that the enables only act at a line start, the bench toggles `vbi_en` and `pal_std` in the idle cycles of a line and checks `blank_o` one full cycle later. It restores both inputs before the next `line_start`.

// File: rtl/vlg_pkg.sv
package vlg_pkg;

   localparam int unsigned LINES_NTSC_IL = 525;
   localparam int unsigned LINES_PAL_IL  = 625;
   localparam int unsigned LINES_NTSC_NI = 262;
   localparam int unsigned LINES_PAL_NI  = 312;

   typedef enum logic [1:0] {
      M_NTSC_NI = 2'b00,
      M_NTSC_IL = 2'b01,
      M_PAL_NI  = 2'b10,
      M_PAL_IL  = 2'b11
   } scan_mode_e;

   function automatic scan_mode_e to_mode(input logic pal, input logic ilace);
      return scan_mode_e'({pal, ilace});
   endfunction

   function automatic int unsigned frame_lines(input scan_mode_e m);
      case (m)
         M_NTSC_IL: return LINES_NTSC_IL;
         M_PAL_IL:  return LINES_PAL_IL;
         M_NTSC_NI: return LINES_NTSC_NI;
         default:   return LINES_PAL_NI;
      endcase
   endfunction

endpackage

// File: rtl/vlg_line_counter.sv
module vlg_line_counter #(
   parameter int LINE_W = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              frame_start,
   input  logic [LINE_W-1:0] total,
   output logic [LINE_W-1:0] line_q,
   output logic [LINE_W-1:0] next_line
);

   localparam logic [LINE_W-1:0] FIRST = LINE_W'(1);

   always_comb begin
      if (frame_start || line_q >= total)
         next_line = FIRST;
      else
         next_line = line_q + FIRST;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_q <= '0;
      else if (line_start)
         line_q <= next_line;
   end

   // R2: frame marker restarts numbering at line 1
   p_frame_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && frame_start) |=> (line_q == FIRST));

   // R2: plain line start steps by one below the frame length
   p_line_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (line_start && !frame_start && line_q != '0 && line_q < total)
      |=> (line_q == $past(line_q) + FIRST));

endmodule

// File: rtl/vlg_range_decode.sv
module vlg_range_decode
   import vlg_pkg::*;
#(
   parameter int LINE_W = 10
) (
   input  logic [LINE_W-1:0] line,
   input  scan_mode_e        mode,
   input  logic              vbi_en,
   input  logic              cap1_en,
   input  logic              cap2_en,
   output logic              vblank
);

   function automatic logic in_rng(input int l, input int lo, input int hi);
      return (l >= lo) && (l <= hi);
   endfunction

   int   ln;
   logic base_hit;
   logic open_hit;
   logic cap_hit;

   assign ln = int'(line);

   always_comb begin
      base_hit = 1'b0;
      open_hit = 1'b0;
      cap_hit  = 1'b0;
      case (mode)
         M_NTSC_IL: begin
            base_hit = in_rng(ln, 1, 21) || in_rng(ln, 263, 284);
            open_hit = in_rng(ln, 10, 21) || in_rng(ln, 273, 284);
            cap_hit  = (cap1_en && ln == 21) || (cap2_en && ln == 284);
         end
         M_PAL_IL: begin
            base_hit = in_rng(ln, 1, 23) || in_rng(ln, 311, 335) || in_rng(ln, 624, 625);
            open_hit = in_rng(ln, 6, 23) || in_rng(ln, 320, 335);
            cap_hit  = (cap1_en && ln == 22) || (cap2_en && ln == 335);
         end
         M_NTSC_NI: begin
            base_hit = in_rng(ln, 1, 17) || in_rng(ln, 261, 262);
            open_hit = in_rng(ln, 10, 21);
            cap_hit  = cap1_en && ln == 21;
         end
         default: begin
            base_hit = in_rng(ln, 1, 22) || in_rng(ln, 311, 312);
            open_hit = in_rng(ln, 7, 23);
            cap_hit  = cap1_en && ln == 22;
         end
      endcase
      vblank = !cap_hit && base_hit && !(vbi_en && open_hit);
   end

endmodule

// File: rtl/vbi_line_gate.sv
module vbi_line_gate
   import vlg_pkg::*;
#(
   parameter int LINE_W  = 10,
   parameter bit PIN_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_start,
   input  logic frame_start,
   input  logic pal_std,
   input  logic interlace,
   input  logic vbi_en,
   input  logic cap1_en,
   input  logic cap2_en,
   input  logic blank_n,
   output logic blank_o
);

   localparam int MAX_LINES = int'(LINES_PAL_IL);

   generate
      if ((1 << LINE_W) <= MAX_LINES) begin : g_bad_width
         $error("vbi_line_gate: LINE_W too small for the longest frame");
      end
   endgenerate

   scan_mode_e        mode;
   logic [LINE_W-1:0] total;
   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] next_line;
   logic              dec_blank;
   logic              vblank_q;
   logic              pin_blank;

   assign mode  = to_mode(pal_std, interlace);
   assign total = LINE_W'(frame_lines(mode));

   vlg_line_counter #(.LINE_W(LINE_W)) i_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_start  (line_start),
      .frame_start (frame_start),
      .total       (total),
      .line_q      (line_q),
      .next_line   (next_line)
   );

   vlg_range_decode #(.LINE_W(LINE_W)) i_dec (
      .line    (next_line),
      .mode    (mode),
      .vbi_en  (vbi_en),
      .cap1_en (cap1_en),
      .cap2_en (cap2_en),
      .vblank  (dec_blank)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         vblank_q <= 1'b1;
      else if (line_start)
         vblank_q <= dec_blank;
   end

   generate
      if (PIN_REG) begin : g_pin_reg
         logic pin_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pin_q <= 1'b0;
            else
               pin_q <= !blank_n;
         end
         assign pin_blank = pin_q;

         // R8: registered pin variant blanks one cycle later
         p_pin_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !blank_n |=> blank_o);
      end else begin : g_pin_comb
         assign pin_blank = !blank_n;

         // R8: pin low blanks in the same cycle
         p_pin_override_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !blank_n |-> blank_o);
      end
   endgenerate

   assign blank_o = vblank_q || pin_blank;

   // R9: decision holds between line starts
   p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_start |=> $stable(vblank_q));

   // R3: line 1 is in the blanking interval of every mode
   p_line_one_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (line_q == LINE_W'(1)) |-> vblank_q);

endmodule

// File: tb/test_vbi_line_gate.sv
module test_vbi_line_gate;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic line_start = 1'b0;
   logic frame_start = 1'b0;
   logic pal_std = 1'b0;
   logic interlace = 1'b1;
   logic vbi_en = 1'b0;
   logic cap1_en = 1'b0;
   logic cap2_en = 1'b0;
   logic blank_n = 1'b1;
   logic blank_o;

   int n_checks = 0;
   int n_fail = 0;
   int m_line = 0;

   always #2.5 clk = ~clk;

   vbi_line_gate i_vbi_line_gate (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .frame_start(frame_start),
      .pal_std(pal_std), .interlace(interlace), .vbi_en(vbi_en),
      .cap1_en(cap1_en), .cap2_en(cap2_en), .blank_n(blank_n), .blank_o(blank_o)
   );

   function automatic int lines_of(input bit pal, input bit il);
      if (il) return pal ? 625 : 525;
      return pal ? 312 : 262;
   endfunction

   function automatic bit exp_blank(input int l, input bit pal, input bit il,
                                    input bit vbi, input bit c1, input bit c2);
      bit b, o, c;
      if (!pal && il) begin
         b = (l <= 21) || (l >= 263 && l <= 284);
         o = (l >= 10 && l <= 21) || (l >= 273 && l <= 284);
         c = (c1 && l == 21) || (c2 && l == 284);
      end else if (pal && il) begin
         b = (l <= 23) || (l >= 311 && l <= 335) || (l >= 624);
         o = (l >= 6 && l <= 23) || (l >= 320 && l <= 335);
         c = (c1 && l == 22) || (c2 && l == 335);
      end else if (!pal) begin
         b = (l <= 17) || (l >= 261);
         o = (l >= 10 && l <= 21);
         c = c1 && l == 21;
      end else begin
         b = (l <= 22) || (l >= 311);
         o = (l >= 7 && l <= 23);
         c = c1 && l == 22;
      end
      if (c) return 1'b0;
      if (vbi && o) return 1'b0;
      return b;
   endfunction

   function automatic string tag_of(input int l, input bit wrapped, input bit pal,
                                    input bit il, input bit vbi, input bit c1, input bit c2);
      if (wrapped) return "R2";
      if ((c1 || c2) && (l == 21 || l == 22 || l == 284 || l == 335)) return "R7";
      if (vbi) return "R6";
      if (!il) return "R5";
      return pal ? "R4" : "R3";
   endfunction

   task automatic check(input string req, input logic act, input logic exp, input int l);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s line %0d: blank_o actual %b expected %b", req, l, act, exp);
      end
   endtask

   task automatic do_line(input bit fs);
      bit wrapped;
      bit e;
      @(negedge clk);
      line_start = 1'b1;
      frame_start = fs;
      @(negedge clk);
      line_start = 1'b0;
      frame_start = 1'b0;
      wrapped = !fs && (m_line >= lines_of(pal_std, interlace));
      m_line = (fs || wrapped) ? 1 : m_line + 1;
      e = exp_blank(m_line, pal_std, interlace, vbi_en, cap1_en, cap2_en);
      check(tag_of(m_line, wrapped, pal_std, interlace, vbi_en, cap1_en, cap2_en),
            blank_o, e, m_line);
      if (($urandom % 16) == 0) begin
         blank_n = 1'b0;
         #1;
         check("R8", blank_o, 1'b1, m_line);
         blank_n = 1'b1;
         #1;
         check("R8", blank_o, e, m_line);
      end
      if (($urandom % 32) == 0) begin
         vbi_en = ~vbi_en;
         pal_std = ~pal_std;
         @(negedge clk);
         check("R9", blank_o, e, m_line);
         vbi_en = ~vbi_en;
         pal_std = ~pal_std;
      end
   endtask

   task automatic run_frames(input bit pal, input bit il, input bit vbi,
                             input bit c1, input bit c2, input int nf);
      @(negedge clk);
      pal_std = pal; interlace = il; vbi_en = vbi; cap1_en = c1; cap2_en = c2;
      for (int f = 0; f < nf; f++)
         for (int k = 0; k < lines_of(pal, il); k++)
            do_line(f == 0 && k == 0);
   endtask

   task automatic finish_run;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      void'($urandom(32'h5EED_0F1D));
      repeat (3) @(negedge clk);
      check("R1", blank_o, 1'b1, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1", blank_o, 1'b1, 0);
      blank_n = 1'b0;
      #1;
      check("R8", blank_o, 1'b1, 0);
      blank_n = 1'b1;

      for (int m = 0; m < 4; m++) begin
         run_frames(m[1], m[0], 1'b0, 1'b0, 1'b0, 2);
         run_frames(m[1], m[0], 1'b1, 1'b0, 1'b0, 1);
         run_frames(m[1], m[0], 1'b1, 1'b1, 1'b1, 1);
         run_frames(m[1], m[0], 1'b0, 1'b1, 1'b1, 1);
      end
      for (int r = 0; r < 6; r++)
         run_frames(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1);
      finish_run();
   end

endmodule